// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request on the chip into two outputs. The first is a system reset. The second is a power-domain reset, which also clears the cause record. The request sources are:

- two watchdog events
- a software request
- an option-load request
- stop-mode and standby-mode entry, each guarded by its own security enable
- a standby-exit event
- the power-on/brown-out indication
- the open-drain reset pin

Every internally raised reset is stretched to a minimum pulse. The block drives that pulse onto the pin through an open-drain pull-down. It senses the pin level and follows an external low for exactly as long as the low lasts. A sticky cause register records every source that fired. A system reset leaves this register alone. Only a software clear strobe or a power reset empties it.

The asynchronous request inputs pass through a synchroniser of `SYNC_STAGES` flops. A low pin or the power-on input pulls the reset outputs low at once. Both outputs release only after synchronising flops. The minimum pulse is `PULSE_CYC` clock cycles. The default of 160 gives 20 µs at an 8 MHz clock.

Top module: `rstgen_hub`

## Requirements
- R1: While `por_n_i` is low, `sys_rst_n_o` and `pwr_rst_n_o` are low at once and `flags_o` is 7'b0000001 (only the power bit, bit 0). Both outputs go high on the second rising edge after `por_n_i` rises.
- R2: A one-cycle watchdog, software or option-load request makes `pad_pull_o` rise after the third rising edge following the request (two synchroniser stages plus one). It then stays high for exactly `PULSE_CYC` cycles. `pad_pull_o` never goes low after fewer than `PULSE_CYC` cycles high.
- R3: An external low on `pad_level_i` forces `sys_rst_n_o` low immediately and for as long as the pin is low. The block does not drive `pad_pull_o` because of it. `sys_rst_n_o` goes high on the second rising edge after the pin goes high, or after `pad_pull_o` falls.
- R4: The pin flag, bit 1, is set only by an external low. The block's own drive of the pin never sets it, including during the synchroniser delay after the drive is released.
- R5: A stop entry with `stop_guard_i` high, or a standby entry with `stdby_guard_i` high, produces a stretched reset and sets the low-power flag, bit 5. The same entry with its guard low has no effect on `pad_pull_o` or `flags_o`.
- R6: Flag bits are: power 0, pin 1, software 2, independent watchdog 3, window watchdog 4, low-power 5, option-load 6. Flags are sticky across system resets. Requests that reach the flags in the same cycle each set their own bit.
- R7: `flag_clr_i` high at a rising edge clears all flags at that edge. A request reaching the flags at the same edge still sets its bit.
- R8: A standby-exit event is a power reset. From the third rising edge after the event, `pwr_rst_n_o` and `sys_rst_n_o` are low for the stretched pulse, and `flags_o` holds only the power bit whenever `pwr_rst_n_o` is low. Both outputs go high on the second rising edge after `pad_pull_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| por_n_i | input | 1 | Power-on/brown-out good, active low reset of the whole block |
| pad_level_i | input | 1 | Sensed level of the open-drain reset pin |
| pad_pull_o | output | 1 | High pulls the reset pin low |
| wwdg_evt_i | input | 1 | Window watchdog expiry |
| iwdg_evt_i | input | 1 | Independent watchdog expiry |
| sw_req_i | input | 1 | Software reset request |
| opt_load_i | input | 1 | Option-load reset request |
| stop_entry_i | input | 1 | Stop-mode entry sequence completed |
| stdby_entry_i | input | 1 | Standby-mode entry sequence completed |
| stop_guard_i | input | 1 | Turn stop entry into a reset |
| stdby_guard_i | input | 1 | Turn standby entry into a reset |
| stdby_exit_i | input | 1 | Standby exit, a power reset source |
| flag_clr_i | input | 1 | Software strobe clearing the cause flags |
| flags_o | output | 7 | Sticky reset cause flags |
| sys_rst_n_o | output | 1 | System reset, active low |
| pwr_rst_n_o | output | 1 | Power-domain reset, active low |

## Verification
A corrupted stretch counter shows on `pad_pull_o` as a pulse of the wrong length. It is visible at the edge where the pulse ends, `PULSE_CYC` cycles after it began. A wrong mask of the block's own drive shows as a spurious pin flag within three cycles of the pull being released. A lost power-class state shows as `pwr_rst_n_o` staying high, or as stale flags, on the edge after the standby-exit request leaves the synchroniser. Wrong flag update logic shows on `flags_o` at the edge where the request or clear takes effect.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   localparam int unsigned NUM_FLAGS = 7;
   localparam int unsigned F_PWR  = 0;
   localparam int unsigned F_PIN  = 1;
   localparam int unsigned F_SW   = 2;
   localparam int unsigned F_IWDG = 3;
   localparam int unsigned F_WWDG = 4;
   localparam int unsigned F_LP   = 5;
   localparam int unsigned F_OPT  = 6;
   typedef logic [NUM_FLAGS-1:0] cause_t;
   localparam cause_t PWR_ONLY = cause_t'(1) << F_PWR;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rstgen_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) begin
               stage_q[s] <= {WIDTH{RST_VAL}};
            end else begin
               stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstgen_stretch.sv
module rstgen_stretch #(
   parameter int unsigned PULSE_CYC = 160
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic load_pwr_i,
   output logic active_o,
   output logic pwr_cls_o
);
   localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad
         $error("rstgen_stretch needs PULSE_CYC >= 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             cls_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         cls_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= CNT_W'(PULSE_CYC);
         cls_q <= cls_q | load_pwr_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == CNT_W'(1)) cls_q <= 1'b0;
      end
   end

   assign active_o  = (cnt_q != '0);
   assign pwr_cls_o = cls_q;
endmodule

// File: rtl/rstgen_flags.sv
module rstgen_flags
   import rstgen_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   pad_s_i,
   input  logic   pull_i,
   input  logic   pwr_hold_i,
   input  logic   pwr_evt_i,
   input  logic   clr_i,
   input  cause_t set_i,
   output cause_t flags_o
);
   logic [SYNC_STAGES-1:0] own_q;
   logic                   own_mask;
   logic                   pin_hit;
   cause_t                 flags_q;
   cause_t                 flags_d;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_own
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) own_q[s] <= 1'b0;
            else         own_q[s] <= (s == 0) ? pull_i : own_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign own_mask = pull_i | (|own_q);
   assign pin_hit  = !pad_s_i && !own_mask;

   always_comb begin
      flags_d = (clr_i ? '0 : flags_q) | set_i;
      if (pin_hit) flags_d[F_PIN] = 1'b1;
      if (pwr_hold_i || pwr_evt_i) flags_d = PWR_ONLY;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= PWR_ONLY;
      else         flags_q <= flags_d;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/rstgen_hub.sv
module rstgen_hub
   import rstgen_pkg::*;
#(
   parameter int unsigned PULSE_CYC   = 160,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk_i,
   input  logic                 por_n_i,
   input  logic                 pad_level_i,
   output logic                 pad_pull_o,
   input  logic                 wwdg_evt_i,
   input  logic                 iwdg_evt_i,
   input  logic                 sw_req_i,
   input  logic                 opt_load_i,
   input  logic                 stop_entry_i,
   input  logic                 stdby_entry_i,
   input  logic                 stop_guard_i,
   input  logic                 stdby_guard_i,
   input  logic                 stdby_exit_i,
   input  logic                 flag_clr_i,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 sys_rst_n_o,
   output logic                 pwr_rst_n_o
);
   localparam int unsigned NREQ = 6;
   localparam int unsigned Q_EXIT = 0, Q_SW = 1, Q_IWDG = 2, Q_WWDG = 3, Q_LP = 4, Q_OPT = 5;

   logic [NREQ-1:0] req_raw, req_s;
   logic            lp_req;
   logic            pad_s;
   logic            stretch_on, pwr_cls;
   logic            int_load;
   cause_t          set_vec;
   logic            sys_arst_n, pwr_arst_n;
   logic            sys_q, pwr_q;

   assign lp_req = (stop_entry_i & stop_guard_i) | (stdby_entry_i & stdby_guard_i);

   always_comb begin
      req_raw         = '0;
      req_raw[Q_EXIT] = stdby_exit_i;
      req_raw[Q_SW]   = sw_req_i;
      req_raw[Q_IWDG] = iwdg_evt_i;
      req_raw[Q_WWDG] = wwdg_evt_i;
      req_raw[Q_LP]   = lp_req;
      req_raw[Q_OPT]  = opt_load_i;
   end

   rstgen_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk_i(clk_i), .arst_ni(por_n_i), .d_i(req_raw), .q_o(req_s));

   rstgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pad_sync (
      .clk_i(clk_i), .arst_ni(por_n_i), .d_i(pad_level_i), .q_o(pad_s));

   assign int_load = |req_s;

   rstgen_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
      .clk_i(clk_i), .rst_ni(por_n_i), .load_i(int_load),
      .load_pwr_i(req_s[Q_EXIT]), .active_o(stretch_on), .pwr_cls_o(pwr_cls));

   always_comb begin
      set_vec         = '0;
      set_vec[F_SW]   = req_s[Q_SW];
      set_vec[F_IWDG] = req_s[Q_IWDG];
      set_vec[F_WWDG] = req_s[Q_WWDG];
      set_vec[F_LP]   = req_s[Q_LP];
      set_vec[F_OPT]  = req_s[Q_OPT];
   end

   rstgen_flags #(.SYNC_STAGES(SYNC_STAGES)) u_flags (
      .clk_i(clk_i), .rst_ni(por_n_i), .pad_s_i(pad_s), .pull_i(pad_pull_o),
      .pwr_hold_i(!pwr_rst_n_o), .pwr_evt_i(req_s[Q_EXIT]), .clr_i(flag_clr_i),
      .set_i(set_vec), .flags_o(flags_o));

   assign pwr_arst_n = por_n_i & ~pwr_cls;
   assign sys_arst_n = por_n_i & ~pwr_cls & pad_level_i;

   rstgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pwr_sync (
      .clk_i(clk_i), .arst_ni(pwr_arst_n), .d_i(1'b1), .q_o(pwr_q));

   rstgen_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sys_sync (
      .clk_i(clk_i), .arst_ni(sys_arst_n), .d_i(!stretch_on), .q_o(sys_q));

   assign pad_pull_o  = stretch_on;
   assign pwr_rst_n_o = pwr_q;
   assign sys_rst_n_o = sys_q;
endmodule

// File: rtl/rstgen_hub_chk.sv
module rstgen_hub_chk #(
   parameter int unsigned PULSE_CYC = 160
) (
   input logic       clk_i,
   input logic       por_n_i,
   input logic       pad_level_i,
   input logic       pad_pull_o,
   input logic       flag_clr_i,
   input logic [6:0] flags_o,
   input logic       sys_rst_n_o,
   input logic       pwr_rst_n_o
);
   logic [31:0] high_cnt;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i)        high_cnt <= '0;
      else if (pad_pull_o) high_cnt <= (high_cnt == 32'hFFFF_FFFF) ? high_cnt : high_cnt + 1;
      else                 high_cnt <= '0;
   end

   // R2: a drive of the pin never ends before the minimum width
   a_r2_min_width: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $fell(pad_pull_o) |-> (high_cnt >= PULSE_CYC));

   // R3: a low pin always holds the system reset
   a_r3_pin_holds_sys: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !pad_level_i |-> !sys_rst_n_o);

   // R8: power reset implies system reset
   a_r8_pwr_covers_sys: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !pwr_rst_n_o |-> !sys_rst_n_o);

   // R8: only the power bit survives while the power reset is held
   a_r8_pwr_flags: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !pwr_rst_n_o |-> (flags_o == 7'b0000001));

   // R6: without a clear or a power reset, no flag is ever lost
   a_r6_sticky: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!$past(flag_clr_i) && $past(pwr_rst_n_o) && pwr_rst_n_o)
         |-> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind rstgen_hub rstgen_hub_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk_i(clk_i), .por_n_i(por_n_i), .pad_level_i(pad_level_i),
   .pad_pull_o(pad_pull_o), .flag_clr_i(flag_clr_i), .flags_o(flags_o),
   .sys_rst_n_o(sys_rst_n_o), .pwr_rst_n_o(pwr_rst_n_o));

// File: tb/rstgen_hub_test.sv
module rstgen_hub_test;
   localparam int PULSE = 160;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic ext_low = 1'b0;
   logic wwdg = 0, iwdg = 0, sw = 0, opt = 0;
   logic stop_e = 0, stdby_e = 0, stop_g = 0, stdby_g = 0, exit_e = 0, clr = 0;
   logic pull, sys_n, pwr_n;
   logic [6:0] flags;
   wire pad_line = ~(pull | ext_low);

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   rstgen_hub #(.PULSE_CYC(PULSE), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .por_n_i(por_n), .pad_level_i(pad_line), .pad_pull_o(pull),
      .wwdg_evt_i(wwdg), .iwdg_evt_i(iwdg), .sw_req_i(sw), .opt_load_i(opt),
      .stop_entry_i(stop_e), .stdby_entry_i(stdby_e), .stop_guard_i(stop_g),
      .stdby_guard_i(stdby_g), .stdby_exit_i(exit_e), .flag_clr_i(clr),
      .flags_o(flags), .sys_rst_n_o(sys_n), .pwr_rst_n_o(pwr_n));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flags();
      clr = 1'b1; step(1); clr = 1'b0;
   endtask

   task automatic measure_pulse(output int w);
      w = 0;
      while (pull && w < 2000) begin w++; step(1); end
   endtask

   task automatic t_reset();
      step(3);
      chk(sys_n == 0, "R1 sys low in por", sys_n, 0);
      chk(pwr_n == 0, "R1 pwr low in por", pwr_n, 0);
      chk(flags == 7'h01, "R1 flags in por", flags, 7'h01);
      por_n = 1'b1;
      step(1);
      chk(sys_n == 0, "R1 sys held one edge", sys_n, 0);
      step(1);
      chk(sys_n == 1 && pwr_n == 1, "R1 release after two edges", {sys_n, pwr_n}, 2'b11);
      chk(pull == 0, "R1 no pull after por", pull, 0);
   endtask

   task automatic t_watchdog();
      int w;
      clear_flags();
      wwdg = 1; step(1); wwdg = 0;
      step(1);
      chk(pull == 0, "R2 no pull before third edge", pull, 0);
      step(1);
      chk(pull == 1, "R2 pull after third edge", pull, 1);
      chk(sys_n == 0, "R3 sys low while pulling", sys_n, 0);
      measure_pulse(w);
      chk(w == PULSE, "R2 pulse width", w, PULSE);
      chk(sys_n == 0, "R3 sys held after pull falls", sys_n, 0);
      step(1);
      chk(sys_n == 0, "R3 sys held one edge", sys_n, 0);
      step(1);
      chk(sys_n == 1, "R3 sys released", sys_n, 1);
      step(3);
      chk(flags == 7'h10, "R4 own drive leaves pin flag clear, R6 wwdg bit", flags, 7'h10);
   endtask

   task automatic t_multi();
      int w;
      clear_flags();
      wwdg = 1; iwdg = 1; sw = 1; step(1); wwdg = 0; iwdg = 0; sw = 0;
      step(2);
      measure_pulse(w);
      chk(w == PULSE, "R2 multi pulse width", w, PULSE);
      step(4);
      chk(flags == 7'h1C, "R6 simultaneous flags", flags, 7'h1C);
      chk(pwr_n == 1, "R6 sticky through system reset", pwr_n, 1);
   endtask

   task automatic t_ext_pin();
      bit pulled = 0;
      clear_flags();
      ext_low = 1'b1;
      #1;
      chk(sys_n == 0, "R3 sys low at once", sys_n, 0);
      for (int i = 0; i < 12; i++) begin step(1); if (pull) pulled = 1; end
      chk(pulled == 0, "R3 no stretch for pin", pulled, 0);
      chk(sys_n == 0, "R3 sys tracks pin", sys_n, 0);
      chk(flags == 7'h02, "R4 pin flag set", flags, 7'h02);
      ext_low = 1'b0;
      step(1);
      chk(sys_n == 0, "R3 sys held one edge after pin", sys_n, 0);
      step(1);
      chk(sys_n == 1, "R3 sys released after pin", sys_n, 1);
   endtask

   task automatic t_low_power();
      bit pulled = 0;
      int w;
      clear_flags();
      stop_g = 0; stdby_g = 0;
      stop_e = 1; stdby_e = 1; step(1); stop_e = 0; stdby_e = 0;
      for (int i = 0; i < 8; i++) begin step(1); if (pull) pulled = 1; end
      chk(pulled == 0, "R5 unguarded entry no pulse", pulled, 0);
      chk(flags == 7'h00, "R5 unguarded entry no flag", flags, 0);
      stdby_g = 1;
      stdby_e = 1; step(1); stdby_e = 0;
      step(2);
      chk(pull == 1, "R5 guarded standby entry pulls", pull, 1);
      measure_pulse(w);
      step(4);
      chk(flags == 7'h20, "R5 low-power flag", flags, 7'h20);
      stdby_g = 0; stop_g = 1;
      clear_flags();
      stop_e = 1; step(1); stop_e = 0;
      step(2);
      chk(pull == 1, "R5 guarded stop entry pulls", pull, 1);
      measure_pulse(w);
      step(4);
      chk(flags == 7'h20, "R5 stop low-power flag", flags, 7'h20);
      stop_g = 0;
   endtask

   task automatic t_clear();
      int w;
      sw = 1; step(1); sw = 0;
      step(2); measure_pulse(w); step(4);
      chk(flags == 7'h24, "R7 before clear", flags, 7'h24);
      opt = 1; step(1); opt = 0;
      step(1);
      clr = 1; step(1); clr = 0;
      chk(flags == 7'h40, "R7 clear with same-edge request", flags, 7'h40);
      measure_pulse(w); step(4);
      clear_flags();
      chk(flags == 7'h00, "R7 plain clear", flags, 0);
   endtask

   task automatic t_standby_exit();
      int w;
      wwdg = 1; step(1); wwdg = 0;
      step(2); measure_pulse(w); step(4);
      exit_e = 1; step(1); exit_e = 0;
      step(1);
      chk(pwr_n == 1, "R8 pwr high before third edge", pwr_n, 1);
      step(1);
      chk(pwr_n == 0 && sys_n == 0, "R8 power reset asserted", {pwr_n, sys_n}, 0);
      chk(flags == 7'h01, "R8 flags power only", flags, 7'h01);
      measure_pulse(w);
      chk(w == PULSE, "R8 power pulse width", w, PULSE);
      step(1);
      chk(pwr_n == 0, "R8 pwr held one edge", pwr_n, 0);
      step(1);
      chk(pwr_n == 1 && sys_n == 1, "R8 release", {pwr_n, sys_n}, 2'b11);
      chk(flags == 7'h01, "R8 flags after release", flags, 7'h01);
   endtask

   initial begin
      t_reset();
      t_watchdog();
      t_multi();
      t_ext_pin();
      t_low_power();
      t_clear();
      t_standby_exit();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule